// File: doc/BRIEF.md
# Segmented paged address translator

This block maps a 32-bit virtual word address onto a 22-bit physical word address for a machine with 16-bit words. A virtual address has three fields. A relative segment number selects a two-word segment descriptor from a table in memory. The descriptor locates a page table. A page number selects one page table entry in that table. The entry supplies the physical page frame, and the word offset within a 1024-word page passes through unchanged.

The descriptor table is found through a packed table register, `dtar_i`. That register also carries the number of segments the table holds. Any segment number at or beyond that count is rejected before memory is touched.

The walk runs over a single-word synchronous memory port. The port returns read data one cycle after the request. On a successful translation the block writes the page table entry back. The write-back marks the page as used, and on a write access it also clears the entry's unmodified flag. When mapping is disabled, the address passes straight through, truncated to 22 bits. Only one translation is handled at a time.

Top module: `segpage_xlate`

## Requirements
- R1: After reset `busy_o`, `done_o`, `fault_o` and `mem_req_o` are low.
- R2: A start with `map_en_i` low raises `done_o` on the next clock with `fault_o` low and `pa_o = va_i[21:0]`, and issues no memory request.
- R3: With mapping on, the relative segment is `va_i[25:16]` and the segment count is `dtar_i[31:22]`. A relative segment greater than or equal to the count completes on the next clock with `fault_o` high, fault kind 1, `fault_va_o = va_i`, and no memory request.
- R4: The descriptor table base is `{dtar_i[21:16], dtar_i[14:0], 1'b0}`, and `dtar_i[15]` is ignored. The first descriptor word is read at base + 2 × relative segment and the second at the next word.
- R5: If bit 15 of the first descriptor word is set, the walk stops after the two descriptor reads. It completes with fault kind 2 two clocks after the start, and `fault_va_o = va_i`.
- R6: The page table base is `{first_word[5:0], second_word[15:0]}`, and the entry is read at base + `va_i[15:10]`. If entry bit 15 (valid) is clear, the result is fault kind 3 with `fault_va_o = va_i` and no write.
- R7: A successful translation completes four clocks after the start, with `pa_o = {entry[11:0], va_i[9:0]}` and `fault_o` low. It makes three reads and one write.
- R8: The write-back stores the entry with bit 14 (used) set. On a write access (`we_i` high) it also clears bit 13 (unmodified). All other bits are kept.
- R9: A start while `busy_o` is high is ignored: it produces no extra completion and does not change the result in flight.
- R10: `done_o` is a one-cycle strobe that is never high while busy. `fault_kind_o` is 0 exactly when a completion has no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a translation (taken only when idle) |
| we_i | input | 1 | Access is a write |
| map_en_i | input | 1 | Mapping enable; low passes the address through |
| va_i | input | 32 | Virtual address |
| dtar_i | input | 32 | Packed table register: count [31:22], base high [21:16], base low [14:0] |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Completion strobe |
| fault_o | output | 1 | Completion carried a fault |
| fault_kind_o | output | 3 | 0 none, 1 segment limit, 2 segment descriptor, 3 page missing |
| pa_o | output | 22 | Physical word address |
| fault_va_o | output | 32 | Virtual address that faulted |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 22 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after a read request |

## Verification
The assertions assume two things about the inputs. First, `dtar_i` stays constant for the whole of a walk. Second, `mem_rdata_i` holds the word addressed one clock earlier. The bench meets both: it programs the table register once before any traffic, and its memory model registers read data on the request edge. The sweep covers every page of in-range, limit-faulted and descriptor-faulted segments, for both reads and writes. The bench computes expected frames, addresses and entry updates from the field layout stated in the requirements.

// File: rtl/segpage_pkg.sv
package segpage_pkg;
  typedef enum logic [2:0] {
    FK_NONE      = 3'd0,
    FK_SEG_LIMIT = 3'd1,
    FK_SEG_DESC  = 3'd2,
    FK_PAGE      = 3'd3
  } fault_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SD0,
    ST_SD1,
    ST_PTE,
    ST_EVAL
  } walk_state_e;
endpackage

// File: rtl/segpage_addr.sv
module segpage_addr #(
  parameter int PA_W  = 22,
  parameter int W_W   = 16,
  parameter int SEG_W = 10,
  parameter int PG_W  = 6,
  parameter int OFF_W = 10
) (
  input  logic [SEG_W-1:0]      rel_seg_i,
  input  logic [SEG_W-1:0]      seg_cnt_i,
  input  logic [PA_W-W_W-1:0]   base_hi_i,
  input  logic [W_W-2:0]        base_lo_i,
  input  logic [PG_W-1:0]       page_q_i,
  input  logic [OFF_W-1:0]      off_q_i,
  input  logic                  we_q_i,
  input  logic [PA_W-W_W-1:0]   w0_lo_q_i,
  input  logic [W_W-1:0]        rdata_i,
  output logic                  over_limit_o,
  output logic [PA_W-1:0]       sd_addr_o,
  output logic [PA_W-1:0]       pte_addr_o,
  output logic [PA_W-1:0]       pa_map_o,
  output logic [W_W-1:0]        pte_upd_o
);
  localparam int PPN_W   = PA_W - OFF_W;
  localparam int USED_B  = W_W - 2;
  localparam int UNMOD_B = W_W - 3;

  logic [PA_W-1:0] tbl_base;
  logic [PA_W-1:0] pt_base;

  assign over_limit_o = rel_seg_i >= seg_cnt_i;
  assign tbl_base     = {base_hi_i, base_lo_i, 1'b0};
  assign sd_addr_o    = tbl_base + PA_W'({rel_seg_i, 1'b0});

  // rdata holds the second descriptor word while the entry address is used
  assign pt_base    = {w0_lo_q_i, rdata_i};
  assign pte_addr_o = pt_base + PA_W'(page_q_i);

  assign pa_map_o = {rdata_i[PPN_W-1:0], off_q_i};

  always_comb begin
    pte_upd_o         = rdata_i;
    pte_upd_o[USED_B] = 1'b1;
    if (we_q_i) pte_upd_o[UNMOD_B] = 1'b0;
  end
endmodule

// File: rtl/segpage_ctrl.sv
module segpage_ctrl
  import segpage_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 22,
  parameter int W_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                we_i,
  input  logic                map_en_i,
  input  logic [VA_W-1:0]     va_i,
  input  logic                over_limit_i,
  input  logic [PA_W-1:0]     sd_addr_i,
  input  logic [PA_W-1:0]     pte_addr_i,
  input  logic [PA_W-1:0]     pa_map_i,
  input  logic [W_W-1:0]      pte_upd_i,
  input  logic                rd_top_i,
  input  logic [PA_W-W_W-1:0] rd_lo_i,
  output logic [VA_W-1:0]     va_q_o,
  output logic                we_q_o,
  output logic [PA_W-W_W-1:0] w0_lo_q_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                fault_o,
  output logic [2:0]          fault_kind_o,
  output logic [PA_W-1:0]     pa_o,
  output logic [VA_W-1:0]     fault_va_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [PA_W-1:0]     mem_addr_o,
  output logic [W_W-1:0]      mem_wdata_o
);
  walk_state_e     state_q;
  logic [PA_W-1:0] sd_q;
  logic [PA_W-1:0] pte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      va_q_o       <= '0;
      we_q_o       <= 1'b0;
      w0_lo_q_o    <= '0;
      sd_q         <= '0;
      pte_q        <= '0;
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
      fault_kind_o <= FK_NONE;
      pa_o         <= '0;
      fault_va_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          va_q_o <= va_i;
          we_q_o <= we_i;
          if (!map_en_i) begin
            done_o       <= 1'b1;
            fault_o      <= 1'b0;
            fault_kind_o <= FK_NONE;
            pa_o         <= va_i[PA_W-1:0];
          end else if (over_limit_i) begin
            done_o       <= 1'b1;
            fault_o      <= 1'b1;
            fault_kind_o <= FK_SEG_LIMIT;
            fault_va_o   <= va_i;
            pa_o         <= '0;
          end else begin
            sd_q    <= sd_addr_i;
            state_q <= ST_SD0;
          end
        end
        ST_SD0: state_q <= ST_SD1;
        ST_SD1: begin
          w0_lo_q_o <= rd_lo_i;
          if (rd_top_i) begin
            done_o       <= 1'b1;
            fault_o      <= 1'b1;
            fault_kind_o <= FK_SEG_DESC;
            fault_va_o   <= va_q_o;
            pa_o         <= '0;
            state_q      <= ST_IDLE;
          end else begin
            state_q <= ST_PTE;
          end
        end
        ST_PTE: begin
          pte_q   <= pte_addr_i;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
          if (!rd_top_i) begin
            fault_o      <= 1'b1;
            fault_kind_o <= FK_PAGE;
            fault_va_o   <= va_q_o;
            pa_o         <= '0;
          end else begin
            fault_o      <= 1'b0;
            fault_kind_o <= FK_NONE;
            pa_o         <= pa_map_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_SD0: begin
        mem_req_o  = 1'b1;
        mem_addr_o = sd_q;
      end
      ST_SD1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = sd_q + PA_W'(1);
      end
      ST_PTE: begin
        mem_req_o  = 1'b1;
        mem_addr_o = pte_addr_i;
      end
      ST_EVAL: if (rd_top_i) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = pte_q;
        mem_wdata_o = pte_upd_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 22,
  parameter int W_W   = 16,
  parameter int SEG_W = 10,
  parameter int PG_W  = 6,
  parameter int OFF_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             we_i,
  input  logic             map_en_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [VA_W-1:0]  dtar_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [2:0]       fault_kind_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [VA_W-1:0]  fault_va_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [W_W-1:0]   mem_wdata_o,
  input  logic [W_W-1:0]   mem_rdata_i
);
  localparam int SEG_LO = OFF_W + PG_W;

  logic [VA_W-1:0]     va_q;
  logic                we_q;
  logic [PA_W-W_W-1:0] w0_lo_q;
  logic                over_limit;
  logic [PA_W-1:0]     sd_addr, pte_addr, pa_map;
  logic [W_W-1:0]      pte_upd;
  logic                unused_dtar;

  assign unused_dtar = dtar_i[W_W-1];

  segpage_addr #(
    .PA_W(PA_W), .W_W(W_W), .SEG_W(SEG_W), .PG_W(PG_W), .OFF_W(OFF_W)
  ) addr_i (
    .rel_seg_i    (va_i[SEG_LO +: SEG_W]),
    .seg_cnt_i    (dtar_i[VA_W-1 -: SEG_W]),
    .base_hi_i    (dtar_i[PA_W-1:W_W]),
    .base_lo_i    (dtar_i[W_W-2:0]),
    .page_q_i     (va_q[OFF_W +: PG_W]),
    .off_q_i      (va_q[OFF_W-1:0]),
    .we_q_i       (we_q),
    .w0_lo_q_i    (w0_lo_q),
    .rdata_i      (mem_rdata_i),
    .over_limit_o (over_limit),
    .sd_addr_o    (sd_addr),
    .pte_addr_o   (pte_addr),
    .pa_map_o     (pa_map),
    .pte_upd_o    (pte_upd)
  );

  segpage_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .W_W(W_W)
  ) ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .we_i         (we_i),
    .map_en_i     (map_en_i),
    .va_i         (va_i),
    .over_limit_i (over_limit),
    .sd_addr_i    (sd_addr),
    .pte_addr_i   (pte_addr),
    .pa_map_i     (pa_map),
    .pte_upd_i    (pte_upd),
    .rd_top_i     (mem_rdata_i[W_W-1]),
    .rd_lo_i      (mem_rdata_i[PA_W-W_W-1:0]),
    .va_q_o       (va_q),
    .we_q_o       (we_q),
    .w0_lo_q_o    (w0_lo_q),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .fault_kind_o (fault_kind_o),
    .pa_o         (pa_o),
    .fault_va_o   (fault_va_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o)
  );
endmodule

// File: rtl/segpage_xlate_chk.sv
module segpage_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 22,
  parameter int SEG_W = 10,
  parameter int PG_W  = 6,
  parameter int OFF_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             map_en_i,
  input logic [VA_W-1:0]  va_i,
  input logic [SEG_W-1:0] lim_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             fault_o,
  input logic [2:0]       fault_kind_o,
  input logic [PA_W-1:0]  pa_o,
  input logic [VA_W-1:0]  fault_va_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic             wd_used_i
);
  localparam int SEG_LO = OFF_W + PG_W;

  assert_passthrough_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !map_en_i |=> done_o && !fault_o && pa_o == $past(va_i[PA_W-1:0]));

  assert_idle_no_mem_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  assert_seg_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && map_en_i && (va_i[SEG_LO +: SEG_W] >= lim_i)
    |=> done_o && fault_o && fault_kind_o == 3'd1 && fault_va_o == $past(va_i));

  assert_wb_used_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o && wd_used_i);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  assert_kind_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_o == (fault_kind_o != 3'd0)));
endmodule

bind segpage_xlate segpage_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .SEG_W(SEG_W), .PG_W(PG_W), .OFF_W(OFF_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .map_en_i     (map_en_i),
  .va_i         (va_i),
  .lim_i        (dtar_i[VA_W-1 -: SEG_W]),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .fault_kind_o (fault_kind_o),
  .pa_o         (pa_o),
  .fault_va_o   (fault_va_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .wd_used_i    (mem_wdata_o[W_W-2])
);

// File: tb/segpage_xlate_tb.sv
module segpage_xlate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [21:0] TBL_BASE = 22'h10200;
  localparam logic [21:0] PT_BASE  = 22'h20000;
  localparam int NSEG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, we = 1'b0, map_en = 1'b0;
  logic [31:0] va = '0;
  logic [31:0] dtar;
  logic        busy, done, fault;
  logic [2:0]  kind;
  logic [21:0] pa;
  logic [31:0] fva;
  logic        req, mwe;
  logic [21:0] maddr;
  logic [15:0] wdata;
  logic [15:0] rdata = '0;

  logic [15:0] mem [int unsigned];
  int          req_cnt = 0;
  logic [21:0] req_log [8];
  int          checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segpage_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .we_i(we), .map_en_i(map_en),
    .va_i(va), .dtar_i(dtar), .busy_o(busy), .done_o(done), .fault_o(fault),
    .fault_kind_o(kind), .pa_o(pa), .fault_va_o(fva), .mem_req_o(req),
    .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (req) begin
      req_log[req_cnt % 8] = maddr;
      req_cnt = req_cnt + 1;
      if (mwe) mem[maddr] = wdata;
      else rdata <= mem.exists(maddr) ? mem[maddr] : 16'h0;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] v, input logic w, input logic men,
                       output int lat, output int reqs, output int r0);
    @(negedge clk);
    va = v; we = w; map_en = men; start = 1'b1; r0 = req_cnt;
    @(posedge clk); #1;
    start = 1'b0; lat = 0;
    while (!done && lat < 20) begin
      @(posedge clk); #1;
      lat++;
    end
    reqs = req_cnt - r0;
  endtask

  function automatic logic [11:0] ppn_of(int s, int p);
    return 12'((s * 64 + p) ^ 12'h5A5);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat, reqs, r0, d_cnt;
    logic [21:0] pte_a;
    logic [15:0] pte_old, pte_exp;
    logic [31:0] v;
    // count 4, base hi 01, bit 15 set (ignored), base lo 0100
    dtar = {10'd4, 6'h01, 1'b1, 15'h0100};
    for (int s = 0; s < NSEG; s++) begin
      mem[TBL_BASE + 22'(2*s)]     = {(s == 2), 9'h0, 6'h02};
      mem[TBL_BASE + 22'(2*s + 1)] = 16'(s * 64);
      for (int p = 0; p < 64; p++)
        mem[PT_BASE + 22'(s*64 + p)] = {(p % 5 != 3), 1'b0, 1'b1, 1'b0, ppn_of(s, p)};
    end

    #(CLK_PERIOD * 3);
    #1;
    chk(!busy && !done && !fault && !req, "R1", "reset outputs", {busy, done, fault, req}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: pass-through
    for (int i = 0; i < 6; i++) begin
      v = 32'hF0000000 ^ (32'h00123457 * i);
      xlate(v, i[0], 1'b0, lat, reqs, r0);
      chk(done && !fault && pa == v[21:0], "R2", "passthrough pa", pa, v[21:0]);
      chk(lat == 0 && reqs == 0, "R2", "passthrough latency/reqs", lat * 16 + reqs, 0);
    end

    // mapped sweep: segments 0..5, all pages, read then write
    for (int s = 0; s < NSEG + 2; s++)
      for (int p = 0; p < 64; p++)
        for (int w = 0; w < 2; w++) begin
          v = {6'h2A, 10'(s), 6'(p), 10'((p * 37 + s * 11) % 1024)};
          pte_a = PT_BASE + 22'(s*64 + p);
          pte_old = mem.exists(pte_a) ? mem[pte_a] : 16'h0;
          xlate(v, w[0], 1'b1, lat, reqs, r0);
          if (s >= NSEG) begin
            chk(fault && kind == 3'd1 && fva == v, "R3", "limit fault", {kind, fva}, {3'd1, v});
            chk(lat == 0 && reqs == 0, "R3", "limit latency/reqs", lat * 16 + reqs, 0);
          end else begin
            chk(req_log[r0 % 8] == TBL_BASE + 22'(2*s), "R4", "descriptor addr",
                req_log[r0 % 8], TBL_BASE + 22'(2*s));
            chk(req_log[(r0 + 1) % 8] == TBL_BASE + 22'(2*s + 1), "R4", "descriptor addr 2",
                req_log[(r0 + 1) % 8], TBL_BASE + 22'(2*s + 1));
            if (s == 2) begin
              chk(fault && kind == 3'd2 && fva == v, "R5", "desc fault", {kind, fva}, {3'd2, v});
              chk(lat == 2 && reqs == 2, "R5", "desc latency/reqs", lat * 16 + reqs, 2 * 16 + 2);
            end else begin
              chk(req_log[(r0 + 2) % 8] == pte_a, "R6", "entry addr", req_log[(r0 + 2) % 8], pte_a);
              if (p % 5 == 3) begin
                chk(fault && kind == 3'd3 && fva == v, "R6", "page fault", {kind, fva}, {3'd3, v});
                chk(reqs == 3 && mem[pte_a] == pte_old, "R6", "no write on page fault",
                    mem[pte_a], pte_old);
              end else begin
                chk(!fault && kind == 3'd0 && pa == {ppn_of(s, p), v[9:0]}, "R7", "mapped pa",
                    pa, {ppn_of(s, p), v[9:0]});
                chk(lat == 4 && reqs == 4, "R7", "mapped latency/reqs", lat * 16 + reqs, 4 * 16 + 4);
                pte_exp = pte_old | 16'h4000;
                if (w == 1) pte_exp = pte_exp & ~16'h2000;
                chk(mem[pte_a] == pte_exp, "R8", "entry write-back", mem[pte_a], pte_exp);
              end
            end
          end
        end

    // R9: starts while busy are ignored
    v = {6'h0, 10'd1, 6'd1, 10'h055};
    @(negedge clk);
    va = v; we = 1'b0; map_en = 1'b1; start = 1'b1;
    @(negedge clk);
    va = 32'h003FFFFF; map_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    d_cnt = 0;
    for (int c = 0; c < 10; c++) begin
      @(posedge clk); #1;
      if (done) begin
        d_cnt++;
        chk(!fault && pa == {ppn_of(1, 1), 10'h055}, "R9", "busy start result",
            pa, {ppn_of(1, 1), 10'h055});
      end
    end
    chk(d_cnt == 1, "R9", "single completion", d_cnt, 1);

    // R10: strobe width after a completion
    xlate({6'h0, 10'd0, 6'd0, 10'h3FF}, 1'b0, 1'b1, lat, reqs, r0);
    @(posedge clk); #1;
    chk(!done, "R10", "done one cycle", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule